// File: doc/BRIEF.md
# Reservation Monitor for Linked Load and Conditional Store

This block sits in front of a small shared word memory used by two requesters. Each port can issue four kinds of access: a plain read, a plain write, a linked read and a conditional write. A linked read returns the addressed word and places a reservation for that port on the address. A later conditional write from the same port writes the word only if that reservation is still intact. It answers 1 when the write took place and 0 when it did not. Software builds atomic read-modify-write sequences, such as an exchange of a register with a memory word, by looping on the conditional write until it answers 1. No bus lock is needed.

Each port keeps one reservation. The reservation is lost when the other port writes the same address, either with a plain write or with a successful conditional write. It is also lost when the owning port issues any conditional write. At most one access is served per cycle. Port 0 always has priority, and port 1 sees its ready signal low in any cycle in which port 0 requests. Every accepted access produces exactly one response one cycle later.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no response is valid, every memory word reads 0 and no port holds a reservation, so a conditional write issued straight after reset answers 0 and leaves memory unchanged.
- R2: An access is accepted in a cycle where its port has req and ready high. The op code is 2'b00 for a plain read, 2'b01 for a plain write, 2'b10 for a linked read and 2'b11 for a conditional write. A plain read returns the addressed word. A plain write stores wdata and returns 0.
- R3: A linked read returns the addressed word and sets a reservation for its port on that address.
- R4: A conditional write whose port holds an intact reservation on the same address stores wdata and returns 1.
- R5: A plain write, or a successful conditional write, by one port to the address reserved by the other port clears that reservation. A later conditional write from the other port then answers 0 and writes nothing.
- R6: Every conditional write clears its own port's reservation, whether it succeeds or fails, so a second conditional write without a new linked read answers 0.
- R7: A conditional write to an address other than its port's reserved address answers 0 and writes nothing.
- R8: When both ports request in the same cycle, only port 0 is accepted and port1 ready is low in that cycle. Port 1 is accepted in the next cycle in which port 0 does not request.
- R9: Each accepted access raises its port's rvalid for exactly the following cycle, with the result on rdata. rvalid is never high without an accepted access. A conditional write result has all bits above bit 0 at zero.
- R10: Plain reads, the port's own plain writes and linked reads by the other port leave a reservation intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_req | input | 1 | Port 0 access request |
| p0_op | input | 2 | Port 0 access kind |
| p0_addr | input | AW | Port 0 word address |
| p0_wdata | input | DW | Port 0 write data |
| p0_ready | output | 1 | Port 0 may be accepted this cycle |
| p0_rvalid | output | 1 | Port 0 response valid |
| p0_rdata | output | DW | Port 0 read data or write status |
| p1_req | input | 1 | Port 1 access request |
| p1_op | input | 2 | Port 1 access kind |
| p1_addr | input | AW | Port 1 word address |
| p1_wdata | input | DW | Port 1 write data |
| p1_ready | output | 1 | Port 1 may be accepted this cycle |
| p1_rvalid | output | 1 | Port 1 response valid |
| p1_rdata | output | DW | Port 1 read data or write status |

## Verification
Directed sequences separate the ways a reservation can end: an intact pair that must succeed, a pair broken by the other port's plain write, a pair broken by the other port's successful conditional write, a pair broken by the port's own earlier conditional write, and a conditional write to a different address. Sequences that must keep the reservation, such as own plain writes, plain reads and linked reads by the other port, show that clearing is not over-eager. Simultaneous requests expose the priority and the stall. Random traffic on four addresses, with both ports interleaved, mixes these cases in orders the directed tests do not cover.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    localparam int NPORT = 2;
    localparam int PW    = $clog2(NPORT);

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_LINK  = 2'b10,
        OP_COND  = 2'b11
    } op_e;

    function automatic logic is_plain_write(input op_e op);
        return op == OP_WRITE;
    endfunction

    function automatic logic returns_word(input op_e op);
        return (op == OP_READ) || (op == OP_LINK);
    endfunction

endpackage

// File: rtl/llsc_arb.sv
module llsc_arb
    import llsc_pkg::*;
(
    input  logic [NPORT-1:0] req,
    output logic [NPORT-1:0] ready,
    output logic [NPORT-1:0] gnt,
    output logic [PW-1:0]    gnt_id
);

    genvar gi;
    generate
        for (gi = 0; gi < NPORT; gi++) begin : g_prio
            if (gi == 0) begin : g_top
                assign ready[gi] = 1'b1;
            end else begin : g_low
                assign ready[gi] = ~(|req[gi-1:0]);
            end
            assign gnt[gi] = req[gi] & ready[gi];
        end
    endgenerate

    always_comb begin
        gnt_id = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (gnt[i]) gnt_id = PW'(i);
        end
    end

endmodule

// File: rtl/llsc_resv.sv
module llsc_resv
    import llsc_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          own_go,
    input  op_e           cur_op,
    input  logic [AW-1:0] cur_addr,
    input  logic          wr_en,
    output logic          hit
);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
    } resv_t;

    resv_t r_q;
    logic  addr_eq;

    assign addr_eq = (r_q.addr == cur_addr);
    assign hit     = r_q.valid & addr_eq;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else if (own_go) begin
            if (cur_op == OP_LINK) begin
                r_q.valid <= 1'b1;
                r_q.addr  <= cur_addr;
            end else if (cur_op == OP_COND) begin
                r_q.valid <= 1'b0;
            end
        end else if (wr_en && hit) begin
            r_q.valid <= 1'b0;
        end
    end

endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata_q
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
            rdata_q <= '0;
        end else begin
            rdata_q <= words[addr];
            if (we) words[addr] <= wdata;
        end
    end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          p0_req,
    input  logic [1:0]    p0_op,
    input  logic [AW-1:0] p0_addr,
    input  logic [DW-1:0] p0_wdata,
    output logic          p0_ready,
    output logic          p0_rvalid,
    output logic [DW-1:0] p0_rdata,
    input  logic          p1_req,
    input  logic [1:0]    p1_op,
    input  logic [AW-1:0] p1_addr,
    input  logic [DW-1:0] p1_wdata,
    output logic          p1_ready,
    output logic          p1_rvalid,
    output logic [DW-1:0] p1_rdata
);

    typedef struct packed {
        op_e           op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } access_t;

    access_t          acc   [NPORT];
    logic [NPORT-1:0] req_v;
    logic [NPORT-1:0] rdy_v;
    logic [NPORT-1:0] gnt_v;
    logic [PW-1:0]    gnt_id;
    logic [NPORT-1:0] hit_v;

    access_t          cur;
    logic             cur_go;
    logic             cond_ok;
    logic             wr_en;

    logic [NPORT-1:0] rvalid_q;
    op_e              kind_q;
    logic             status_q;
    logic [DW-1:0]    mem_q;
    logic [DW-1:0]    resp;

    assign acc[0] = '{op: op_e'(p0_op), addr: p0_addr, wdata: p0_wdata};
    assign acc[1] = '{op: op_e'(p1_op), addr: p1_addr, wdata: p1_wdata};
    assign req_v  = {p1_req, p0_req};

    llsc_arb i_arb (
        .req    (req_v),
        .ready  (rdy_v),
        .gnt    (gnt_v),
        .gnt_id (gnt_id)
    );

    assign cur     = acc[gnt_id];
    assign cur_go  = |gnt_v;
    assign cond_ok = hit_v[gnt_id] & (cur.op == OP_COND);
    assign wr_en   = cur_go & (is_plain_write(cur.op) | cond_ok);

    genvar gp;
    generate
        for (gp = 0; gp < NPORT; gp++) begin : g_port
            llsc_resv #(.AW(AW)) i_resv (
                .clk      (clk),
                .rst      (rst),
                .own_go   (gnt_v[gp]),
                .cur_op   (cur.op),
                .cur_addr (cur.addr),
                .wr_en    (wr_en),
                .hit      (hit_v[gp])
            );
        end
    endgenerate

    llsc_mem #(.AW(AW), .DW(DW)) i_mem (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .addr    (cur.addr),
        .wdata   (cur.wdata),
        .rdata_q (mem_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= '0;
            kind_q   <= OP_READ;
            status_q <= 1'b0;
        end else begin
            rvalid_q <= gnt_v;
            if (cur_go) begin
                kind_q   <= cur.op;
                status_q <= cond_ok;
            end
        end
    end

    always_comb begin
        if (returns_word(kind_q))   resp = mem_q;
        else if (kind_q == OP_COND) resp = {{(DW-1){1'b0}}, status_q};
        else                        resp = '0;
    end

    assign p0_ready  = rdy_v[0];
    assign p1_ready  = rdy_v[1];
    assign p0_rvalid = rvalid_q[0];
    assign p1_rvalid = rvalid_q[1];
    assign p0_rdata  = rvalid_q[0] ? resp : '0;
    assign p1_rdata  = rvalid_q[1] ? resp : '0;

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          p0_req,
    input logic [1:0]    p0_op,
    input logic          p0_ready,
    input logic          p0_rvalid,
    input logic [DW-1:0] p0_rdata,
    input logic          p1_req,
    input logic [1:0]    p1_op,
    input logic          p1_ready,
    input logic          p1_rvalid,
    input logic [DW-1:0] p1_rdata
);

    // R9: accepted access answers in the next cycle
    p_resp_next_r9: assert property (@(posedge clk) disable iff (rst)
        (p0_req && p0_ready) |=> p0_rvalid);

    p_resp_next1_r9: assert property (@(posedge clk) disable iff (rst)
        (p1_req && p1_ready) |=> p1_rvalid);

    // R9: no response without a prior acceptance
    p_resp_cause_r9: assert property (@(posedge clk) disable iff (rst)
        p1_rvalid |-> $past(p1_req && p1_ready));

    // R8: simultaneous requests stall port 1
    p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (p0_req && p1_req) |-> !p1_ready);

    // R8: never two acceptances in one cycle
    p_single_r8: assert property (@(posedge clk) disable iff (rst)
        !(p0_req && p0_ready && p1_req && p1_ready));

    // R9: conditional write status uses bit 0 only
    p_status_r9: assert property (@(posedge clk) disable iff (rst)
        (p0_rvalid && $past(p0_op) == 2'b11) |-> (p0_rdata[DW-1:1] == '0));

    p_status1_r9: assert property (@(posedge clk) disable iff (rst)
        (p1_rvalid && $past(p1_op) == 2'b11) |-> (p1_rdata[DW-1:1] == '0));

endmodule

bind llsc_monitor llsc_monitor_chk #(.AW(AW), .DW(DW)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .p0_req    (p0_req),
    .p0_op     (p0_op),
    .p0_ready  (p0_ready),
    .p0_rvalid (p0_rvalid),
    .p0_rdata  (p0_rdata),
    .p1_req    (p1_req),
    .p1_op     (p1_op),
    .p1_ready  (p1_ready),
    .p1_rvalid (p1_rvalid),
    .p1_rdata  (p1_rdata)
);

// File: tb/test_llsc_monitor.sv
`timescale 1ns/1ps
module test_llsc_monitor;

    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          p0_req = 1'b0, p1_req = 1'b0;
    logic [1:0]    p0_op = '0, p1_op = '0;
    logic [AW-1:0] p0_addr = '0, p1_addr = '0;
    logic [DW-1:0] p0_wdata = '0, p1_wdata = '0;
    logic          p0_ready, p1_ready, p0_rvalid, p1_rvalid;
    logic [DW-1:0] p0_rdata, p1_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [DW-1:0] m_mem [16];
    logic          m_rv  [2];
    logic [AW-1:0] m_ra  [2];

    always #2 clk = ~clk;

    llsc_monitor #(.AW(AW), .DW(DW)) i_llsc_monitor (.*);

    function automatic logic [DW-1:0] model(int p, logic [1:0] op,
                                            logic [AW-1:0] a, logic [DW-1:0] wd);
        int o = 1 - p;
        logic ok;
        logic [DW-1:0] r = '0;
        case (op)
            2'b00: r = m_mem[a];
            2'b01: begin
                m_mem[a] = wd;
                if (m_rv[o] && m_ra[o] == a) m_rv[o] = 1'b0;
            end
            2'b10: begin
                r = m_mem[a];
                m_rv[p] = 1'b1;
                m_ra[p] = a;
            end
            default: begin
                ok = m_rv[p] && (m_ra[p] == a);
                m_rv[p] = 1'b0;
                if (ok) begin
                    m_mem[a] = wd;
                    if (m_rv[o] && m_ra[o] == a) m_rv[o] = 1'b0;
                end
                r = {{(DW-1){1'b0}}, ok};
            end
        endcase
        return r;
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(int p, logic rq, logic [1:0] op, logic [AW-1:0] a,
                         logic [DW-1:0] wd);
        if (p == 0) begin
            p0_req = rq; p0_op = op; p0_addr = a; p0_wdata = wd;
        end else begin
            p1_req = rq; p1_op = op; p1_addr = a; p1_wdata = wd;
        end
    endtask

    task automatic do_op(int p, logic [1:0] op, logic [AW-1:0] a,
                         logic [DW-1:0] wd, string tag);
        logic [DW-1:0] exp;
        @(negedge clk);
        drive(p, 1'b1, op, a, wd);
        exp = model(p, op, a, wd);
        @(negedge clk);
        if (p == 0) begin
            check({tag, " rvalid"}, {31'b0, p0_rvalid}, 1);
            check(tag, p0_rdata, exp);
        end else begin
            check({tag, " rvalid"}, {31'b0, p1_rvalid}, 1);
            check(tag, p1_rdata, exp);
        end
        drive(p, 1'b0, 2'b00, '0, '0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] e0, e1;
        void'($urandom(32'd2015));
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        for (int i = 0; i < 2; i++) begin m_rv[i] = 0; m_ra[i] = '0; end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 p0 rvalid after reset", {31'b0, p0_rvalid}, 0);
        check("R1 p1 rvalid after reset", {31'b0, p1_rvalid}, 0);

        do_op(0, 2'b11, 4'd3, 32'd5, "R1 cond after reset");
        do_op(0, 2'b00, 4'd3, 0, "R1 memory untouched");
        do_op(1, 2'b00, 4'd12, 0, "R1 memory zero");

        do_op(0, 2'b01, 4'd1, 32'hA5, "R2 write");
        do_op(1, 2'b00, 4'd1, 0, "R2 read back");

        do_op(0, 2'b10, 4'd1, 0, "R3 linked read");
        do_op(0, 2'b11, 4'd1, 32'd77, "R4 cond success");
        do_op(1, 2'b00, 4'd1, 0, "R4 data written");

        do_op(0, 2'b11, 4'd1, 32'd88, "R6 second cond fails");
        do_op(0, 2'b00, 4'd1, 0, "R6 no write");

        do_op(0, 2'b10, 4'd2, 0, "R3 link 2");
        do_op(1, 2'b01, 4'd2, 32'd11, "R5 other write");
        do_op(0, 2'b11, 4'd2, 32'd22, "R5 cond after write fails");
        do_op(0, 2'b00, 4'd2, 0, "R5 memory keeps other write");

        do_op(0, 2'b10, 4'd5, 0, "R3 link p0");
        do_op(1, 2'b10, 4'd5, 0, "R10 link p1 same addr");
        do_op(1, 2'b11, 4'd5, 32'd9, "R5 p1 cond success");
        do_op(0, 2'b11, 4'd5, 32'd8, "R5 p0 cond after other cond");
        do_op(0, 2'b00, 4'd5, 0, "R5 memory");

        do_op(1, 2'b10, 4'd6, 0, "R3 link 6");
        do_op(1, 2'b11, 4'd7, 32'd3, "R7 cond wrong addr");
        do_op(1, 2'b00, 4'd7, 0, "R7 no write");
        do_op(1, 2'b11, 4'd6, 32'd3, "R6 reservation gone");

        do_op(0, 2'b10, 4'd8, 0, "R3 link 8");
        do_op(0, 2'b01, 4'd8, 32'd4, "R10 own write");
        do_op(1, 2'b00, 4'd8, 0, "R10 other read");
        do_op(1, 2'b10, 4'd8, 0, "R10 other link");
        do_op(0, 2'b11, 4'd8, 32'd6, "R10 cond still succeeds");

        // R8 priority
        @(negedge clk);
        drive(0, 1'b1, 2'b01, 4'd9, 32'h31);
        drive(1, 1'b1, 2'b00, 4'd9, 0);
        e0 = model(0, 2'b01, 4'd9, 32'h31);
        e1 = model(1, 2'b00, 4'd9, 0);
        #1;
        check("R8 p1 ready low", {31'b0, p1_ready}, 0);
        @(negedge clk);
        check("R8 p0 served", {31'b0, p0_rvalid}, 1);
        check("R8 p0 rdata", p0_rdata, e0);
        check("R8 p1 not served", {31'b0, p1_rvalid}, 0);
        drive(0, 1'b0, 2'b00, '0, '0);
        #1;
        check("R8 p1 ready high", {31'b0, p1_ready}, 1);
        @(negedge clk);
        check("R8 p1 served", {31'b0, p1_rvalid}, 1);
        check("R8 p1 sees p0 write", p1_rdata, e1);
        check("R9 p0 single response", {31'b0, p0_rvalid}, 0);
        drive(1, 1'b0, 2'b00, '0, '0);

        for (int n = 0; n < 400; n++) begin
            int p = int'($urandom_range(1, 0));
            logic [1:0] op = 2'($urandom_range(3, 0));
            logic [AW-1:0] a = AW'($urandom_range(3, 0));
            logic [DW-1:0] wd = $urandom;
            string tg;
            case (op)
                2'b00, 2'b01: tg = "R2 random";
                2'b10:        tg = "R3 random";
                default:      tg = "R4 random";
            endcase
            do_op(p, op, a, wd, tg);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule